// File: doc/BRIEF.md
# Timing Command Receiver with Per-Command Delays

This block sits at the front of a detector readout channel and takes the fast timing and control word that arrives once every 40 MHz crossing period over twelve parallel lines. Each line carries two bits per period: one sampled on the rising clock edge and one sampled on the following falling edge. The block puts the two halves back together into a 24-bit word, splits off the 12-bit crossing identifier, and decodes the command flags.

Commands are sent ahead of the crossing they refer to, nominally 16 periods early. The link cannot delay its lines by different amounts, so every decoded output passes through its own delay line. Each line has a latency of 0 to 63 periods, set through a small configuration port. This lets each command meet the local data pipeline in the correct cycle. The header-only and crossing-veto commands have the same local meaning, so they are merged into one reject strobe.

Top module: `tfc_cmd_rx`

## Requirements
- R1: A value sampled on lane k at a rising edge becomes word bit 2k+1. The value on the same lane at the next falling edge becomes word bit 2k. The assembled word is registered at the rising edge after that.
- R2: Bit 0 is synch, bit 1 is header-only, bit 2 is crossing veto, bit 3 is non-zero-suppressed readout, bit 4 is crossing-counter reset, and bits 23..12 are the crossing identifier. Bits 11..5 have no effect on any output.
- R3: The reject strobe is the logical OR of the header-only bit and the crossing-veto bit of the same word.
- R4: Take a word whose rising half is sampled at edge n. Its command strobe appears after edge n+1+d, where d is the delay programmed for that output.
- R5: A command bit set in one word gives a strobe exactly one cycle long. Set in consecutive words, it gives back-to-back one-cycle strobes.
- R6: When cfg_we_i is high at a rising edge, cfg_dly_i is stored as the delay of the output chosen by cfg_sel_i: 0 synch, 1 reject, 2 non-zero-suppressed, 3 counter reset, 4 crossing identifier. The new delay applies from that edge onward.
- R7: A write with cfg_sel_i of 5, 6 or 7 changes no delay.
- R8: Reset clears all delays to 0 and empties every delay line, so all outputs read 0.
- R9: The five delays are independent. The crossing identifier is delayed by its own setting and appears together with any command that has the same delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 40 MHz crossing clock; both edges used for lane sampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lane_i | input | 12 | Double-rate word lanes |
| cfg_we_i | input | 1 | Delay register write enable |
| cfg_sel_i | input | 3 | Selects which output's delay is written |
| cfg_dly_i | input | 6 | Delay value in cycles, 0 to 63 |
| synch_o | output | 1 | Delayed synch strobe |
| reject_o | output | 1 | Delayed strobe for header-only or veto |
| nzs_o | output | 1 | Delayed non-zero-suppressed strobe |
| bxrst_o | output | 1 | Delayed crossing-counter reset strobe |
| bxid_o | output | 12 | Delayed crossing identifier |

## Verification
A word whose odd half meets rising edge n has been assembled after edge n+1. Each output then shows it d edges later, so the result for that word is due after edge n+1+d. The bench keeps a table of the words it drove, indexed by rising edge. Each output is sampled at every falling edge, before the next lanes are driven. The expected value at that point comes from the word driven 2+d falling-edge iterations earlier, and is 0 when no word was driven there. The checks run against a sweep of delay sets that covers every value from 0 to 63 on every output.

// File: rtl/tfc_rx_pkg.sv
package tfc_rx_pkg;
   localparam int NUM_CH   = 5;
   localparam int SEL_W    = 3;
   localparam int NUM_FLAG = 5;

   // Word bit positions of the command flags
   localparam int BIT_SYNCH = 0;
   localparam int BIT_HDR   = 1;
   localparam int BIT_VETO  = 2;
   localparam int BIT_NZS   = 3;
   localparam int BIT_BXRST = 4;

   // Delay channel indices (configuration select values)
   typedef enum logic [SEL_W-1:0] {
      CH_SYNCH  = 3'd0,
      CH_REJECT = 3'd1,
      CH_NZS    = 3'd2,
      CH_BXRST  = 3'd3,
      CH_BXID   = 3'd4
   } chan_e;
endpackage

// File: rtl/tfc_ddr_deser.sv
module tfc_ddr_deser #(
   parameter int LANES = 12
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [LANES-1:0]   lane_i,
   output logic [2*LANES-1:0] word_o
);
   localparam int WORD_W = 2 * LANES;

   logic [LANES-1:0]  rise_q;
   logic [LANES-1:0]  fall_q;
   logic [WORD_W-1:0] merged;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rise_q <= '0;
      else         rise_q <= lane_i;
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fall_q <= '0;
      else         fall_q <= lane_i;
   end

   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         merged[2*k+1] = rise_q[k];
         merged[2*k]   = fall_q[k];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_o <= '0;
      else         word_o <= merged;
   end
endmodule

// File: rtl/tfc_dly_regs.sv
module tfc_dly_regs
   import tfc_rx_pkg::*;
#(
   parameter int DLY_W = 6
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         we_i,
   input  logic [SEL_W-1:0]             sel_i,
   input  logic [DLY_W-1:0]             val_i,
   output logic [NUM_CH-1:0][DLY_W-1:0] dly_o
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            dly_o[c] <= '0;
         else if (we_i && (sel_i == SEL_W'(c)))
            dly_o[c] <= val_i;
      end
   end
endmodule

// File: rtl/tfc_delay_line.sv
module tfc_delay_line #(
   parameter int W       = 1,
   parameter int MAX_DLY = 63,
   parameter int DLY_W   = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [W-1:0]     din_i,
   input  logic [DLY_W-1:0] tap_i,
   output logic [W-1:0]     dout_o
);
   if (MAX_DLY == 0) begin : g_pass
      logic unused_tap;
      assign unused_tap = ^tap_i;
      assign dout_o     = din_i;
   end else begin : g_shift
      logic [W-1:0]     stage [1:MAX_DLY];
      logic [DLY_W-1:0] tap_c;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 1; i <= MAX_DLY; i++) stage[i] <= '0;
         end else begin
            stage[1] <= din_i;
            for (int i = 2; i <= MAX_DLY; i++) stage[i] <= stage[i-1];
         end
      end

      assign tap_c  = (tap_i > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : tap_i;
      assign dout_o = (tap_c == '0) ? din_i : stage[tap_c];
   end
endmodule

// File: rtl/tfc_cmd_rx.sv
module tfc_cmd_rx
   import tfc_rx_pkg::*;
#(
   parameter int LANES   = 12,
   parameter int ID_W    = 12,
   parameter int MAX_DLY = 63,
   parameter int DLY_W   = $clog2(MAX_DLY + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LANES-1:0] lane_i,
   input  logic             cfg_we_i,
   input  logic [2:0]       cfg_sel_i,
   input  logic [DLY_W-1:0] cfg_dly_i,
   output logic             synch_o,
   output logic             reject_o,
   output logic             nzs_o,
   output logic             bxrst_o,
   output logic [ID_W-1:0]  bxid_o
);
   localparam int WORD_W = 2 * LANES;
   localparam int ID_LSB = WORD_W - ID_W;
   localparam int NFLAG  = NUM_CH - 1;

   if (ID_W < 1 || ID_LSB < NUM_FLAG) begin : g_bad_id
      $error("crossing identifier overlaps command flags");
   end
   if (MAX_DLY < 0 || (MAX_DLY + 1) > (1 << DLY_W)) begin : g_bad_dly
      $error("delay width too small for MAX_DLY");
   end
   if (SEL_W != 3) begin : g_bad_sel
      $error("select width mismatch");
   end

   logic [WORD_W-1:0]               word;
   logic [NUM_CH-1:0][DLY_W-1:0]    dly;
   logic [NFLAG-1:0]                flag_in;
   logic [NFLAG-1:0]                flag_out;

   tfc_ddr_deser #(.LANES(LANES)) u_deser (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lane_i (lane_i),
      .word_o (word)
   );

   tfc_dly_regs #(.DLY_W(DLY_W)) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i),
      .sel_i  (cfg_sel_i),
      .val_i  (cfg_dly_i),
      .dly_o  (dly)
   );

   always_comb begin
      flag_in[CH_SYNCH]  = word[BIT_SYNCH];
      flag_in[CH_REJECT] = word[BIT_HDR] | word[BIT_VETO];
      flag_in[CH_NZS]    = word[BIT_NZS];
      flag_in[CH_BXRST]  = word[BIT_BXRST];
   end

   if (ID_LSB > NUM_FLAG) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^word[ID_LSB-1:NUM_FLAG];
   end

   for (genvar c = 0; c < NFLAG; c++) begin : g_flag
      tfc_delay_line #(.W(1), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_line (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .din_i  (flag_in[c]),
         .tap_i  (dly[c]),
         .dout_o (flag_out[c])
      );
   end

   tfc_delay_line #(.W(ID_W), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_id_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (word[WORD_W-1:ID_LSB]),
      .tap_i  (dly[CH_BXID]),
      .dout_o (bxid_o)
   );

   assign synch_o  = flag_out[CH_SYNCH];
   assign reject_o = flag_out[CH_REJECT];
   assign nzs_o    = flag_out[CH_NZS];
   assign bxrst_o  = flag_out[CH_BXRST];
endmodule

// File: rtl/tfc_cmd_rx_chk.sv
module tfc_cmd_rx_chk
   import tfc_rx_pkg::*;
#(
   parameter int LANES = 12,
   parameter int ID_W  = 12,
   parameter int DLY_W = 6
) (
   input logic                         clk_i,
   input logic                         rst_ni,
   input logic [LANES-1:0]             lane_i,
   input logic [2*LANES-1:0]           word_i,
   input logic [NUM_CH-1:0][DLY_W-1:0] dly_i,
   input logic                         cfg_we_i,
   input logic [2:0]                   cfg_sel_i,
   input logic [DLY_W-1:0]             cfg_dly_i,
   input logic                         synch_o,
   input logic                         reject_o,
   input logic [ID_W-1:0]              bxid_o
);
   localparam int WORD_W = 2 * LANES;

   logic [1:0] since_rst;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_rise
      a_r1_rise_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (since_rst >= 2'd2) |-> (word_i[2*k+1] == $past(lane_i[k], 2)));
   end

   a_r3_reject_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 2'd1 && dly_i[CH_REJECT] == DLY_W'(1)
       && $past(dly_i[CH_REJECT]) == DLY_W'(1))
      |-> (reject_o == ($past(word_i[BIT_HDR]) | $past(word_i[BIT_VETO]))));

   a_r4_synch_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 2'd1 && dly_i[CH_SYNCH] == DLY_W'(1)
       && $past(dly_i[CH_SYNCH]) == DLY_W'(1))
      |-> (synch_o == $past(word_i[BIT_SYNCH])));

   a_r9_bxid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 2'd1 && dly_i[CH_BXID] == DLY_W'(1)
       && $past(dly_i[CH_BXID]) == DLY_W'(1))
      |-> (bxid_o == $past(word_i[WORD_W-1:WORD_W-ID_W])));

   a_r6_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_sel_i < 3'(NUM_CH))
      |=> (dly_i[$past(cfg_sel_i)] == $past(cfg_dly_i)));

   a_r7_bad_sel_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_we_i || cfg_sel_i >= 3'(NUM_CH)) |=> $stable(dly_i));
endmodule

bind tfc_cmd_rx tfc_cmd_rx_chk #(.LANES(LANES), .ID_W(ID_W), .DLY_W(DLY_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .lane_i    (lane_i),
   .word_i    (word),
   .dly_i     (dly),
   .cfg_we_i  (cfg_we_i),
   .cfg_sel_i (cfg_sel_i),
   .cfg_dly_i (cfg_dly_i),
   .synch_o   (synch_o),
   .reject_o  (reject_o),
   .bxid_o    (bxid_o)
);

// File: tb/tfc_cmd_rx_bench.sv
module tfc_cmd_rx_bench;
   localparam int CLK_PERIOD = 25;
   localparam int LANES      = 12;
   localparam int ID_W       = 12;
   localparam int MAX_DLY    = 63;
   localparam int DLY_W      = 6;
   localparam int NW         = 40;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LANES-1:0] lane = '0;
   logic             cfg_we = 1'b0;
   logic [2:0]       cfg_sel = '0;
   logic [DLY_W-1:0] cfg_dly = '0;
   logic             synch, reject, nzs, bxrst;
   logic [ID_W-1:0]  bxid;

   int n_vec  = 0;
   int n_fail = 0;
   logic [23:0] stim [0:NW-1];
   int          ed   [0:4];
   logic [31:0] lf = 32'h1D2C_3B4A;

   tfc_cmd_rx #(.LANES(LANES), .ID_W(ID_W), .MAX_DLY(MAX_DLY)) u_tfc_cmd_rx (
      .clk_i(clk), .rst_ni(rst_n), .lane_i(lane),
      .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_dly_i(cfg_dly),
      .synch_o(synch), .reject_o(reject), .nzs_o(nzs), .bxrst_o(bxrst),
      .bxid_o(bxid));

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   function automatic logic [LANES-1:0] rise_half(logic [23:0] w);
      for (int k = 0; k < LANES; k++) rise_half[k] = w[2*k+1];
   endfunction

   function automatic logic [LANES-1:0] fall_half(logic [23:0] w);
      for (int k = 0; k < LANES; k++) fall_half[k] = w[2*k];
   endfunction

   // Expected value of output ch for word w (R2, R3)
   function automatic logic [11:0] exp_of(int ch, logic [23:0] w);
      case (ch)
         0: exp_of = {11'd0, w[0]};
         1: exp_of = {11'd0, w[1] | w[2]};
         2: exp_of = {11'd0, w[3]};
         3: exp_of = {11'd0, w[4]};
         default: exp_of = w[23:12];
      endcase
   endfunction

   task automatic check(string req, int ch, logic [11:0] got, logic [11:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s ch%0d at %0t: actual %h expected %h", req, ch, $time, got, exp);
      end
   endtask

   task automatic cfg_write(int sel, int val);
      @(negedge clk) #1;
      cfg_we  = 1'b1;
      cfg_sel = 3'(sel);
      cfg_dly = DLY_W'(val);
      @(posedge clk) #1;
      cfg_we  = 1'b0;
   endtask

   task automatic set_delays(int d0, int d1, int d2, int d3, int d4);
      ed[0] = d0; ed[1] = d1; ed[2] = d2; ed[3] = d3; ed[4] = d4;
      for (int c = 0; c < 5; c++) cfg_write(c, ed[c]);
   endtask

   task automatic fill_random();
      for (int i = 0; i < NW; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         stim[i] = lf[23:0];
      end
   endtask

   // Drive the words and check all five outputs each cycle (R1, R4, R5, R9)
   task automatic run_stream(int ncyc);
      for (int n = 0; n < ncyc; n++) begin
         logic [23:0] cur;
         @(negedge clk);
         for (int c = 0; c < 5; c++) begin
            int idx = n - 2 - ed[c];
            logic [11:0] got;
            logic [11:0] exp;
            exp = (idx >= 0 && idx < NW) ? exp_of(c, stim[idx]) : 12'd0;
            case (c)
               0: got = {11'd0, synch};
               1: got = {11'd0, reject};
               2: got = {11'd0, nzs};
               3: got = {11'd0, bxrst};
               default: got = bxid;
            endcase
            check(c == 4 ? "R9_bxid" : (c == 1 ? "R3_R4_reject" : "R4_R5_strobe"), c, got, exp);
         end
         cur = (n < NW) ? stim[n] : 24'd0;
         #1 lane = rise_half(cur);
         @(posedge clk) #1 lane = fall_half(cur);
      end
   endtask

   task automatic check_all_zero(string req);
      @(negedge clk);
      check(req, 0, {11'd0, synch}, 12'd0);
      check(req, 1, {11'd0, reject}, 12'd0);
      check(req, 2, {11'd0, nzs}, 12'd0);
      check(req, 3, {11'd0, bxrst}, 12'd0);
      check(req, 4, bxid, 12'd0);
   endtask

   initial begin
      for (int c = 0; c < 5; c++) ed[c] = 0;
      repeat (3) @(posedge clk);
      check_all_zero("R8_reset");
      #1 rst_n = 1'b1;
      check_all_zero("R8_after_release");

      // Directed words: R2 reserved bits, R3 merge, R5 back-to-back strobes
      for (int i = 0; i < NW; i++) stim[i] = 24'd0;
      stim[0] = 24'h000002;            // header-only alone
      stim[2] = 24'h000004;            // veto alone
      stim[4] = 24'h000006;            // both
      stim[6] = 24'h000FE0;            // reserved bits only, R2
      stim[8] = 24'hABC001;            // synch with crossing id
      stim[9] = 24'hABD001;            // consecutive synch, R5
      stim[10] = 24'h123008;
      stim[12] = 24'hFFF010;
      stim[13] = 24'h555FFF;
      run_stream(NW + MAX_DLY + 4);

      set_delays(1, 1, 1, 1, 1);
      fill_random();
      run_stream(NW + MAX_DLY + 4);

      // Sweep every delay value on every output (R4, R6, R9)
      for (int d = 0; d < 64; d++) begin
         set_delays(d, (d + 13) % 64, (d + 26) % 64, (d + 39) % 64, (d + 52) % 64);
         fill_random();
         run_stream(NW + MAX_DLY + 4);
      end

      // R7: writes with select 5..7 leave the delays unchanged
      set_delays(3, 9, 17, 40, 63);
      cfg_write(5, 0);
      cfg_write(6, 0);
      cfg_write(7, 0);
      fill_random();
      run_stream(NW + MAX_DLY + 4);

      // R8: reset mid-stream clears lines and delays
      set_delays(20, 21, 22, 23, 24);
      fill_random();
      run_stream(30);
      @(negedge clk) #1 rst_n = 1'b0;
      lane = '0;
      repeat (2) @(posedge clk);
      check_all_zero("R8_mid_reset");
      #1 rst_n = 1'b1;
      for (int c = 0; c < 5; c++) ed[c] = 0;
      repeat (2) @(posedge clk);
      #1;
      fill_random();
      run_stream(NW + 4);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule